// File: doc/BRIEF.md
# Ping-Pong Receive Frame Buffer

This block is the two-stage receive queue of a CAN-style controller. It holds two frame stores and swaps their roles. The receive engine fills whichever store is currently in the background. The CPU reads only the store that is currently in the foreground, and it always reads it through the same small address window. Software therefore never has to track which physical store holds its frame, and it never sees a store while that store is being written.

A frame is committed when the engine pulses its done strobe. If the foreground is empty at that point, the stores swap and the receive-full flag rises. If the foreground is still occupied, the finished frame waits in the background. The CPU releases the foreground by writing a 1 to the receive-full flag. If a frame is waiting at that moment, the stores swap again straight away. If a frame finishes while both stores hold unread frames, that frame is discarded and a sticky overrun flag is raised.

Top module: `rx_pingpong_buf`

## Requirements
- R1: After reset, `rx_full` and `overrun` are 0 and every address of the read window returns 0.
- R2: When `rx_done` is sampled with the foreground empty and no frame pending, `rx_full` is 1 from the next cycle and the window shows the new frame.
- R3: Window map: addresses 0 to 7 are data bytes 0 to 7, address 8 is the stored length code in bits 3:0, and addresses 9 to 12 are identifier bytes with the least significant byte first. Addresses 13 to 15 read 0.
- R4: A data address at or above the effective length reads 0. The effective length is the length code, capped at 8. A length code above 8 reads back unchanged at address 8.
- R5: While the foreground holds an unread frame, the receive engine's writes to the background leave every value in the window unchanged.
- R6: An acknowledge while a completed frame waits in the background swaps the stores. `rx_full` stays 1 and the waiting frame is visible from the next cycle.
- R7: An acknowledge with no frame waiting clears `rx_full` in the next cycle.
- R8: A frame that completes while both stores hold unread frames is dropped and `overrun` sets. Neither held frame changes.
- R9: `overrun` stays 1 until `ovr_clr` is pulsed. A new overrun in the same cycle as `ovr_clr` wins.
- R10: An acknowledge while `rx_full` is 0 has no effect.
- R11: Data bytes offered beyond the eighth in one frame are ignored.
- R12: An acknowledge in the same cycle as `rx_done`, with no frame waiting, leaves `rx_full` at 1 and puts the new frame in the foreground.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_start | input | 1 | Engine begins a frame; latches identifier and length, clears the background data |
| rx_id | input | 29 | Identifier of the arriving frame, sampled with `rx_start` |
| rx_dlc | input | 4 | Length code of the arriving frame, sampled with `rx_start` |
| rx_byte_vld | input | 1 | One data byte is offered |
| rx_byte | input | 8 | Data byte value |
| rx_done | input | 1 | Engine commits the frame |
| cpu_addr | input | 4 | Read window address |
| cpu_rdata | output | 8 | Foreground field at `cpu_addr` (combinational) |
| cpu_ack | input | 1 | CPU writes 1 to the receive-full flag |
| ovr_clr | input | 1 | CPU clears the overrun flag |
| rx_full | output | 1 | Foreground holds an unread frame |
| overrun | output | 1 | Sticky: a frame was dropped |

## Verification
The bench builds the block with its default parameters: a 29-bit identifier, which fills all four identifier bytes of the window, and a maximum of eight data bytes. With the full eight-byte width, the bench can offer a ten-byte frame to test the truncation limit. It can also offer a length code of 12 to test the cap on the effective length. Because there are exactly two stores, three back-to-back frames are enough to reach the waiting-frame swap, the overrun drop, and the acknowledge that coincides with a commit.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int RXQ_ID_W      = 29;
    localparam int RXQ_MAX_BYTES = 8;
    localparam int RXQ_DLC_W     = 4;
    localparam int RXQ_ADDR_W    = 4;
    localparam int RXQ_ID_BYTES  = (RXQ_ID_W + 7) / 8;
    localparam int RXQ_IDX_W     = $clog2(RXQ_MAX_BYTES + 1);

    typedef struct packed {
        logic [RXQ_ID_W-1:0]               id;
        logic [RXQ_DLC_W-1:0]              dlc;
        logic [RXQ_MAX_BYTES-1:0][7:0]     data;
    } rxq_frame_t;

    typedef enum logic [1:0] {
        FLD_DATA = 2'd0,
        FLD_LEN  = 2'd1,
        FLD_ID   = 2'd2,
        FLD_NONE = 2'd3
    } rxq_field_e;

    // Number of data bytes that carry meaning for a given length code.
    function automatic logic [RXQ_IDX_W-1:0] eff_len(input logic [RXQ_DLC_W-1:0] code);
        if (int'(code) > RXQ_MAX_BYTES)
            return RXQ_IDX_W'(RXQ_MAX_BYTES);
        return RXQ_IDX_W'(code);
    endfunction

    function automatic rxq_field_e field_of(input logic [RXQ_ADDR_W-1:0] a);
        if (int'(a) < RXQ_MAX_BYTES)
            return FLD_DATA;
        if (int'(a) == RXQ_MAX_BYTES)
            return FLD_LEN;
        if (int'(a) < RXQ_MAX_BYTES + 1 + RXQ_ID_BYTES)
            return FLD_ID;
        return FLD_NONE;
    endfunction
endpackage

// File: rtl/rxq_slot.sv
module rxq_slot
    import rxq_pkg::*;
#(
    parameter int MAX_BYTES = RXQ_MAX_BYTES
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic [RXQ_ID_W-1:0]  id_in,
    input  logic [RXQ_DLC_W-1:0] dlc_in,
    input  logic                 byte_we,
    input  logic [7:0]           byte_in,
    output rxq_frame_t           frame_o
);
    localparam int IDX_W = $clog2(MAX_BYTES + 1);

    rxq_frame_t       store;
    logic [IDX_W-1:0] wr_idx;
    logic             room;

    assign room = (int'(wr_idx) < MAX_BYTES);

    always_ff @(posedge clk) begin
        if (rst) begin
            store  <= '0;
            wr_idx <= '0;
        end else if (clr) begin
            store.id   <= id_in;
            store.dlc  <= dlc_in;
            store.data <= '0;
            wr_idx     <= '0;
        end else if (byte_we && room) begin
            store.data[wr_idx[$clog2(MAX_BYTES)-1:0]] <= byte_in;
            wr_idx <= wr_idx + 1'b1;
        end
    end

    assign frame_o = store;

    // R11: the write index never passes the byte capacity
    p_idx_cap_r11: assert property (@(posedge clk) disable iff (rst)
        (int'(wr_idx) <= MAX_BYTES));
    p_full_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!room && !clr) |=> $stable(store.data));
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic rx_start,
    input  logic rx_done,
    input  logic cpu_ack,
    input  logic ovr_clr,
    output logic fg_sel,
    output logic fg_full,
    output logic bg_pend,
    output logic ovr,
    output logic start_ok,
    output logic wr_ok
);
    logic blocked;
    logic sel_n, full_n, pend_n, ovr_n, blk_n;
    logic take_ack;

    assign take_ack = cpu_ack & fg_full;
    assign start_ok = ~bg_pend;
    assign wr_ok    = ~bg_pend & ~blocked;

    always_comb begin
        sel_n  = fg_sel;
        full_n = fg_full;
        pend_n = bg_pend;
        ovr_n  = ovr & ~ovr_clr;
        blk_n  = blocked;
        if (take_ack) begin
            if (bg_pend) begin
                sel_n  = ~fg_sel;
                pend_n = 1'b0;
            end else begin
                full_n = 1'b0;
            end
        end
        if (rx_done) begin
            if (bg_pend || blocked) begin
                ovr_n = 1'b1;
            end else if (!full_n) begin
                sel_n  = ~sel_n;
                full_n = 1'b1;
            end else begin
                pend_n = 1'b1;
            end
            blk_n = 1'b0;
        end
        if (rx_start)
            blk_n = bg_pend;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fg_sel  <= 1'b0;
            fg_full <= 1'b0;
            bg_pend <= 1'b0;
            ovr     <= 1'b0;
            blocked <= 1'b0;
        end else begin
            fg_sel  <= sel_n;
            fg_full <= full_n;
            bg_pend <= pend_n;
            ovr     <= ovr_n;
            blocked <= blk_n;
        end
    end

    p_rise_on_done_r2: assert property (@(posedge clk) disable iff (rst)
        (rx_done && !fg_full && !bg_pend && !blocked) |=> fg_full);
    p_pend_needs_fg_r5: assert property (@(posedge clk) disable iff (rst)
        bg_pend |-> fg_full);
    p_swap_keeps_full_r6: assert property (@(posedge clk) disable iff (rst)
        (cpu_ack && bg_pend) |=> (fg_full && fg_sel != $past(fg_sel)));
    p_release_r7: assert property (@(posedge clk) disable iff (rst)
        (cpu_ack && fg_full && !bg_pend && !rx_done) |=> !fg_full);
    p_drop_sets_ovr_r8: assert property (@(posedge clk) disable iff (rst)
        (rx_done && bg_pend) |=> ovr);
    p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (ovr && !ovr_clr) |=> ovr);
    p_idle_ack_r10: assert property (@(posedge clk) disable iff (rst)
        (cpu_ack && !fg_full && !rx_done) |=> (!fg_full && $stable(fg_sel)));
    p_ack_done_r12: assert property (@(posedge clk) disable iff (rst)
        (cpu_ack && rx_done && fg_full && !bg_pend && !blocked) |=> (fg_full && !bg_pend));
endmodule

// File: rtl/rxq_readmux.sv
module rxq_readmux
    import rxq_pkg::*;
(
    input  rxq_frame_t              frame_i,
    input  logic [RXQ_ADDR_W-1:0]   addr,
    output logic [7:0]              rdata
);
    localparam int ID_PAD = RXQ_ID_BYTES * 8;

    logic [ID_PAD-1:0]    id_pad;
    logic [RXQ_IDX_W-1:0] used;
    rxq_field_e           fld;
    int                   id_ofs;

    assign id_pad = ID_PAD'(frame_i.id);
    assign used   = eff_len(frame_i.dlc);
    assign fld    = field_of(addr);
    assign id_ofs = int'(addr) - RXQ_MAX_BYTES - 1;

    always_comb begin
        rdata = 8'h00;
        case (fld)
            FLD_DATA: if (RXQ_IDX_W'(addr) < used)
                          rdata = frame_i.data[addr[$clog2(RXQ_MAX_BYTES)-1:0]];
            FLD_LEN:  rdata = 8'(frame_i.dlc);
            FLD_ID: begin
                for (int b = 0; b < RXQ_ID_BYTES; b++)
                    if (id_ofs == b) rdata = id_pad[b*8 +: 8];
            end
            default:  rdata = 8'h00;
        endcase
    end

    // R4: data beyond the effective length reads zero
    always_comb begin
        if (fld == FLD_DATA && RXQ_IDX_W'(addr) >= used)
            p_unused_zero_r4: assert (rdata == 8'h00);
    end
endmodule

// File: rtl/rx_pingpong_buf.sv
module rx_pingpong_buf
    import rxq_pkg::*;
#(
    parameter int ID_W      = RXQ_ID_W,
    parameter int DLC_W     = RXQ_DLC_W,
    parameter int ADDR_W    = RXQ_ADDR_W,
    parameter int MAX_BYTES = RXQ_MAX_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_start,
    input  logic [ID_W-1:0]   rx_id,
    input  logic [DLC_W-1:0]  rx_dlc,
    input  logic              rx_byte_vld,
    input  logic [7:0]        rx_byte,
    input  logic              rx_done,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic [7:0]        cpu_rdata,
    input  logic              cpu_ack,
    input  logic              ovr_clr,
    output logic              rx_full,
    output logic              overrun
);
    localparam int NSLOT = 2;

    logic       fg_sel, fg_full, bg_pend, ovr, start_ok, wr_ok;
    logic       bg_sel;
    rxq_frame_t slot_q [NSLOT];
    rxq_frame_t fg_frame;

    assign bg_sel = ~fg_sel;

    rxq_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .rx_start (rx_start),
        .rx_done  (rx_done),
        .cpu_ack  (cpu_ack),
        .ovr_clr  (ovr_clr),
        .fg_sel   (fg_sel),
        .fg_full  (fg_full),
        .bg_pend  (bg_pend),
        .ovr      (ovr),
        .start_ok (start_ok),
        .wr_ok    (wr_ok)
    );

    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        logic is_bg;
        assign is_bg = (bg_sel == 1'(k));
        rxq_slot #(.MAX_BYTES(MAX_BYTES)) u_slot (
            .clk     (clk),
            .rst     (rst),
            .clr     (rx_start & start_ok & is_bg),
            .id_in   (rx_id),
            .dlc_in  (rx_dlc),
            .byte_we (rx_byte_vld & wr_ok & is_bg & ~rx_start),
            .byte_in (rx_byte),
            .frame_o (slot_q[k])
        );
    end

    assign fg_frame = slot_q[fg_sel];

    rxq_readmux u_rd (
        .frame_i (fg_frame),
        .addr    (cpu_addr),
        .rdata   (cpu_rdata)
    );

    assign rx_full = fg_full;
    assign overrun = ovr;

    // R5: an unread foreground frame is never modified by the engine
    p_fg_frozen_r5: assert property (@(posedge clk) disable iff (rst)
        (fg_full && !cpu_ack) |=> $stable(fg_frame));
endmodule

// File: tb/sim_rx_pingpong_buf.sv
module sim_rx_pingpong_buf;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [28:0] id;
        logic [3:0]  dlc;
        logic [7:0]  data [8];
    } exp_frame_t;

    logic        clk = 0, rst = 1;
    logic        rx_start = 0, rx_byte_vld = 0, rx_done = 0, cpu_ack = 0, ovr_clr = 0;
    logic [28:0] rx_id = '0;
    logic [3:0]  rx_dlc = '0;
    logic [7:0]  rx_byte = '0;
    logic [3:0]  cpu_addr = '0;
    logic [7:0]  cpu_rdata;
    logic        rx_full, overrun;

    int n_cmp = 0, n_bad = 0;
    exp_frame_t sb [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_pingpong_buf u0 (
        .clk(clk), .rst(rst), .rx_start(rx_start), .rx_id(rx_id), .rx_dlc(rx_dlc),
        .rx_byte_vld(rx_byte_vld), .rx_byte(rx_byte), .rx_done(rx_done),
        .cpu_addr(cpu_addr), .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack),
        .ovr_clr(ovr_clr), .rx_full(rx_full), .overrun(overrun)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input exp_frame_t f, input int a);
        int used;
        used = (f.dlc > 8) ? 8 : int'(f.dlc);
        if (a < 8) return (a < used) ? f.data[a] : 8'h00;
        if (a == 8) return {4'h0, f.dlc};
        if (a < 13) return 8'({3'b000, f.id} >> (8 * (a - 9)));
        return 8'h00;
    endfunction

    task automatic rd(input int a, output logic [7:0] v);
        cpu_addr = 4'(a);
        #1;
        v = cpu_rdata;
    endtask

    // Driver: offers one frame; pushes an expected item if it must be kept.
    task automatic send(input logic [28:0] id, input logic [3:0] dlc, input int nb,
                        input logic [7:0] seed, input bit keep, input bit ack_too);
        exp_frame_t f;
        f.id = id; f.dlc = dlc;
        for (int i = 0; i < 8; i++) f.data[i] = (i < nb) ? seed + 8'(i * 17) : 8'h00;
        @(negedge clk);
        rx_start = 1; rx_id = id; rx_dlc = dlc;
        @(negedge clk);
        rx_start = 0;
        for (int i = 0; i < nb; i++) begin
            rx_byte_vld = 1; rx_byte = seed + 8'(i * 17);
            @(negedge clk);
        end
        rx_byte_vld = 0;
        rx_done = 1; cpu_ack = ack_too;
        @(negedge clk);
        rx_done = 0; cpu_ack = 0;
        if (keep) sb.push_back(f);
    endtask

    // Monitor: pops the oldest expected frame and compares the whole window.
    task automatic consume(input string req);
        exp_frame_t f;
        logic [7:0] v;
        if (sb.size() == 0) begin
            chk({req, " queue"}, 1, 0);
            return;
        end
        f = sb.pop_front();
        chk({req, " rx_full"}, rx_full, 1);
        for (int a = 0; a < 16; a++) begin
            rd(a, v);
            chk($sformatf("%s R3 addr %0d", req, a), v, exp_byte(f, a));
        end
        @(negedge clk);
        cpu_ack = 1;
        @(negedge clk);
        cpu_ack = 0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 rx_full", rx_full, 0);
        chk("R1 overrun", overrun, 0);
        for (int a = 0; a < 16; a++) begin
            rd(a, v);
            chk("R1 window", v, 0);
        end
        // R2 / R3 / R4 / R7: single short frame
        send(29'h1ABCDE12, 4'd3, 3, 8'h11, 1, 0);
        chk("R2 rx_full", rx_full, 1);
        consume("R2");
        chk("R7 rx_full cleared", rx_full, 0);
        // R10: idle ack
        cpu_ack = 1; @(negedge clk); cpu_ack = 0;
        chk("R10 rx_full", rx_full, 0);
        chk("R10 overrun", overrun, 0);
        // R5 / R11 / R6 / R8: fill both, then overflow
        send(29'h0000_0555, 4'd8, 8, 8'h20, 1, 0);
        send(29'h1FFF_FFFF, 4'd5, 10, 8'h40, 1, 0);
        rd(0, v);
        chk("R5 fg untouched", v, 8'h20);
        rd(12, v);
        chk("R5 fg id", v, 8'h00);
        send(29'h0123_4567, 4'd2, 2, 8'h77, 0, 0);
        chk("R8 overrun", overrun, 1);
        consume("R6");
        chk("R6 rx_full kept", rx_full, 1);
        consume("R8 R11");
        chk("R7 rx_full", rx_full, 0);
        chk("R9 sticky", overrun, 1);
        ovr_clr = 1; @(negedge clk); ovr_clr = 0;
        chk("R9 cleared", overrun, 0);
        // R4: length code above 8
        send(29'h0AA_55AA, 4'd12, 8, 8'h05, 1, 0);
        consume("R4");
        // R12: ack coinciding with done
        send(29'h0000_0001, 4'd1, 1, 8'h99, 1, 0);
        begin
            exp_frame_t old;
            old = sb.pop_front();
            send(29'h0000_0002, 4'd4, 4, 8'hC0, 1, 1);
        end
        chk("R12 rx_full", rx_full, 1);
        chk("R12 overrun", overrun, 0);
        consume("R12");
        chk("R12 released", rx_full, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule